// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It watches the line on an enable pulse that runs at sixteen times the bit rate. It confirms each start bit at its midpoint and then samples every following bit at its centre. It gathers five to eight data bits, least significant bit first, and can check an optional even or odd parity bit. It then tests the stop bit. One clock-wide strobe carries each finished character together with parity-error, framing-error and break flags.

A low pulse that has ended by the middle of the start bit is treated as noise, and no character is produced. A line held low through a whole character, including the parity and stop positions, is reported as a break. In that case exactly one character is produced. The receiver then waits for the line to go high before it looks for another start bit.

The format inputs (`word_len`, `par_en`, `par_odd`) are captured when a start bit is first seen. Changing them while a character is in flight has no effect on that character.

The controller has six states:
- `ST_IDLE`: hunting for a start bit. It leaves for `ST_START` when the line is low at a tick.
- `ST_START`: counting to mid-start. It returns to `ST_IDLE` if the line is high on the 8th tick, and otherwise goes to `ST_DATA`.
- `ST_DATA`: one sample every 16 ticks. After the last data bit it goes to `ST_PARITY` if parity is on, or else to `ST_STOP`.
- `ST_PARITY`: one sample, then `ST_STOP`.
- `ST_STOP`: samples the stop bit and emits the character. It goes to `ST_HOLD` on a break, or else to `ST_IDLE`.
- `ST_HOLD`: waits and goes to `ST_IDLE` on the first tick that sees the line high.

Top module: `serial_rx`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `out_data`, `out_perr`, `out_ferr` and `out_brk` are all zero until the first character completes.
- R2: The line passes through a two-flop synchronizer. If the synchronized line is high on the 8th tick after the tick that first saw it low, the receiver returns to hunting and produces no character.
- R3: `word_len` selects the character size: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits arrive LSB first. `out_data` holds them right-aligned, and the bits above the character size are zero.
- R4: When `par_en` is 1, one parity bit follows the data. `par_odd`=0 means the data bits and the parity bit together hold an even number of ones, and `par_odd`=1 means an odd number. A mismatch sets `out_perr`. When `par_en` is 0 there is no parity slot and `out_perr` is 0.
- R5: A stop bit sampled low sets `out_ferr`. A high stop bit clears it.
- R6: If every sampled data bit, the parity bit (when enabled) and the stop bit are all low, `out_brk` is 1 with `out_data` zero and `out_ferr` one. Only one character is produced for the whole low period, and a later normal character is received once the line has gone high again.
- R7: Each character raises `out_valid` for exactly one clock. The data and flags are valid in that clock.
- R8: The format inputs are captured at start detection. Changing them mid-character does not alter that character.
- R9: Characters sent back to back, with a single stop bit and no idle gap, are each received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-clock enable pulse at 16x the bit rate |
| word_len | input | 2 | Character size select, 0..3 for 5..8 bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| out_valid | output | 1 | One-clock strobe for a finished character |
| out_data | output | 8 | Received character, right-aligned |
| out_perr | output | 1 | Parity mismatch |
| out_ferr | output | 1 | Stop bit sampled low |
| out_brk | output | 1 | Whole character time was low |

## Verification
The hardest condition to create is the break hold, where the receiver must stay quiet through a line that keeps being low after the character time ends. From the ports, a long low looks just like a string of start bits. The stimulus holds the line low for about twice a character time and counts strobes to show that exactly one appears. It then releases the line and sends a normal character, which proves that hunting resumes. The glitch case is reached with low pulses of about 1 and 6 ticks, both shorter than the 8-tick confirmation point.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
    } rx_fmt_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_parity.sv
module serial_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              enable,
    input  logic              odd,
    output logic              err
);
    always_comb begin
        err = enable && (((^data) ^ par_bit) != odd);
    end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              tick16,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_perr,
    output logic              out_ferr,
    output logic              out_brk
);
    localparam int CNT_W    = $clog2(OSR);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int MID      = OSR / 2 - 1;
    localparam int LAST     = OSR - 1;
    localparam int MIN_BITS = DATA_W - 3;

    rx_state_e         state, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] data_al;
    logic [IDX_W:0]    n_bits;
    rx_fmt_t           fmt_q;
    logic              par_q;
    logic              all_low;
    logic              rx_s;
    logic              mid_hit;
    logic              bit_hit;
    logic              last_bit;
    logic              perr_w;

    serial_rx_sync #(.STAGES(2), .RESET_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (rx_s)
    );

    always_comb begin
        n_bits   = (IDX_W+1)'(MIN_BITS) + (IDX_W+1)'(fmt_q.wlen);
        mid_hit  = tick16 && (cnt == CNT_W'(MID));
        bit_hit  = tick16 && (cnt == CNT_W'(LAST));
        last_bit = ({1'b0, bit_idx} == (n_bits - 1'b1));
        data_al  = shreg >> ((IDX_W+1)'(DATA_W) - n_bits);
    end

    serial_rx_parity #(.DATA_W(DATA_W)) i_parity (
        .data    (data_al),
        .par_bit (par_q),
        .enable  (fmt_q.par_en),
        .odd     (fmt_q.par_odd),
        .err     (perr_w)
    );

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (tick16 && !rx_s) state_d = ST_START;
            ST_START:  if (mid_hit) state_d = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_hit && last_bit)
                           state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_hit) state_d = ST_STOP;
            ST_STOP:   if (bit_hit) state_d = (all_low && !rx_s) ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (tick16 && rx_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            fmt_q   <= '0;
            par_q   <= 1'b0;
            all_low <= 1'b0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE) begin
                cnt <= '0;
                if (tick16 && !rx_s) begin
                    fmt_q   <= '{wlen: word_len, par_en: par_en, par_odd: par_odd};
                    all_low <= 1'b1;
                    bit_idx <= '0;
                    par_q   <= 1'b0;
                end
            end else if (tick16) begin
                if (mid_hit && state == ST_START) cnt <= '0;
                else if (cnt == CNT_W'(LAST))    cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end
            if (bit_hit && state inside {ST_DATA, ST_PARITY, ST_STOP}) begin
                if (rx_s) all_low <= 1'b0;
                if (state == ST_DATA) begin
                    shreg   <= {rx_s, shreg[DATA_W-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
                if (state == ST_PARITY) par_q <= rx_s;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
            out_ferr  <= 1'b0;
            out_brk   <= 1'b0;
        end else if (state == ST_STOP && bit_hit) begin
            out_valid <= 1'b1;
            out_data  <= data_al;
            out_perr  <= perr_w;
            out_ferr  <= !rx_s;
            out_brk   <= all_low && !rx_s;
        end else begin
            out_valid <= 1'b0;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                                  // R7
    AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_brk) |-> (out_ferr && out_data == '0));                   // R6
    AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rx_s) |=> (state == ST_HOLD));                        // R6
    AST_NO_PERR_UNPARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fmt_q.par_en) |-> !out_perr);                                // R4
    AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && mid_hit && rx_s) |=> (state == ST_IDLE && !out_valid)); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> n_bits) == '0));                                // R3
endmodule

// File: tb/test_serial_rx.sv
module test_serial_rx;
    localparam int BIT_CLK = 64;
    localparam int NVEC    = 8;
    // {wlen[31:30], par_en[29], par_odd[28], bad_par[27], bad_stop[26], data[7:0]}
    localparam logic [31:0] VECS [NVEC] = '{
        32'hC00000A5, 32'h000000FF, 32'h6000003C, 32'hB0000055,
        32'hE8000081, 32'hC400007E, 32'hB8000000, 32'h3000000A
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_perr, out_ferr, out_brk;

    int checks = 0;
    int fails = 0;
    int got_cnt = 0;
    logic [7:0] cap_data, prev_data;
    logic cap_perr, cap_ferr, cap_brk;
    logic [1:0] div = '0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        div    <= div + 1'b1;
        tick16 <= (div == 2'd3);
    end

    serial_rx i_serial_rx (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
        .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
        .out_valid(out_valid), .out_data(out_data), .out_perr(out_perr),
        .out_ferr(out_ferr), .out_brk(out_brk)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_cnt   <= got_cnt + 1;
            prev_data <= cap_data;
            cap_data  <= out_data;
            cap_perr  <= out_perr;
            cap_ferr  <= out_ferr;
            cap_brk   <= out_brk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_bits(input logic v, input int nbits);
        rx_in = v;
        repeat (nbits * BIT_CLK) @(negedge clk);
    endtask

    task automatic send_char(input logic [1:0] wl, input logic pe, input logic po,
                             input logic [7:0] d, input logic badp, input logic bads,
                             input logic flip_fmt);
        int n = 5 + int'(wl);
        logic pbit;
        word_len = wl; par_en = pe; par_odd = po;
        pbit = ^(d & 8'((1 << n) - 1)) ^ po ^ badp;
        hold_bits(1'b0, 1);
        if (flip_fmt) begin word_len = ~wl; par_en = ~pe; par_odd = ~po; end
        for (int i = 0; i < n; i++) hold_bits(d[i], 1);
        if (pe) hold_bits(pbit, 1);
        hold_bits(!bads, 1);
        rx_in = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 valid", out_valid, 0);
        chk("R1 data", out_data, 0);
        chk("R1 flags", {out_perr, out_ferr, out_brk}, 0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 idle after reset", {out_valid, out_data, out_perr, out_ferr, out_brk}, 0);

        // Table-driven characters: R3 R4 R5 R7
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] v = VECS[k];
            int n = 5 + int'(v[31:30]);
            base = got_cnt;
            send_char(v[31:30], v[29], v[28], v[7:0], v[27], v[26], 1'b0);
            hold_bits(1'b1, 2);
            chk($sformatf("R7 count vec%0d", k), got_cnt - base, 1);
            chk($sformatf("R3 data vec%0d", k), cap_data, int'(v[7:0] & 8'((1 << n) - 1)));
            chk($sformatf("R4 perr vec%0d", k), cap_perr, int'(v[29] & v[27]));
            chk($sformatf("R5 ferr vec%0d", k), cap_ferr, int'(v[26]));
            chk($sformatf("R6 no brk vec%0d", k), cap_brk, 0);
        end

        // R2: short glitches rejected
        base = got_cnt;
        rx_in = 1'b0; repeat (5) @(negedge clk); rx_in = 1'b1;
        hold_bits(1'b1, 3);
        rx_in = 1'b0; repeat (24) @(negedge clk); rx_in = 1'b1;
        hold_bits(1'b1, 3);
        chk("R2 glitch no char", got_cnt - base, 0);

        // R6: break held long, one character only, then recovery
        word_len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
        base = got_cnt;
        hold_bits(1'b0, 24);
        chk("R6 break single char", got_cnt - base, 1);
        chk("R6 break flag", cap_brk, 1);
        chk("R6 break ferr", cap_ferr, 1);
        chk("R6 break data", cap_data, 0);
        hold_bits(1'b1, 2);
        chk("R6 no extra after release", got_cnt - base, 1);
        send_char(2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b0);
        hold_bits(1'b1, 2);
        chk("R6 recovery count", got_cnt - base, 2);
        chk("R6 recovery data", cap_data, 8'h5A);

        // R8: format change mid-character ignored
        base = got_cnt;
        send_char(2'd3, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b1);
        hold_bits(1'b1, 2);
        chk("R8 count", got_cnt - base, 1);
        chk("R8 data", cap_data, 8'hC3);
        chk("R8 perr", cap_perr, 0);
        chk("R8 ferr", cap_ferr, 0);

        // R9: back-to-back characters
        base = got_cnt;
        send_char(2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b0);
        send_char(2'd3, 1'b0, 1'b0, 8'h3E, 1'b0, 1'b0, 1'b0);
        hold_bits(1'b1, 2);
        chk("R9 count", got_cnt - base, 2);
        chk("R9 first", prev_data, 8'h96);
        chk("R9 second", cap_data, 8'h3E);
        chk("R9 ferr", cap_ferr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule